// File: doc/BRIEF.md
# Low-Transition Scan Pattern Generator

This block produces the serial scan-in stream for a test-per-scan self-test. A pseudo-random register advances once per shift cycle. It does not feed the chain directly. A wide AND of a few of its stages forms a control bit, and that bit toggles a single flip-flop. The flip-flop's output is what enters the scan chain.

The AND output is 1 only rarely, so the bit shifted in usually repeats for several cycles. Neighbouring scan cells therefore mostly receive the same value, which cuts switching in the logic under test. A larger AND fan-in gives longer runs.

Software or a test controller loads a seed and then holds the shift enable for as long as the chain shifts. A built-in counter of chain length flags the end of every pattern.

Top module: `lt_scan_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the register takes the default seed (the low `LFSR_W` bits of 64'h96F0_5A3C_ACE1_1D27, so 16'h1D27 at width 16). `scan_out` and `pattern_done` go to 0, and the shift count clears.
- R2: Each enabled shift moves the register one place toward its top bit. Bit 0 takes the XOR of the tap stages, which at width 16 are bits 15, 13, 12 and 10 (a maximal-length polynomial).
- R3: The control bit is the AND of the `AND_K` stages at bit positions j*(LFSR_W/AND_K), for j = 0 to AND_K-1. At width 16 these are bits 0 and 8 for fan-in 2, and bits 0, 5 and 10 for fan-in 3. The control bit is taken from the register value held before the shift.
- R4: On each enabled shift, `scan_out` inverts if the control bit is 1 and keeps its value if it is 0.
- R5: With `shift_en` low and no load, `scan_out`, the register and the shift count all hold. `pattern_done` is 0.
- R6: A high `seed_load` writes `seed_in` into the register, clears `scan_out` to 0 and clears the shift count. It takes priority over `shift_en` in the same cycle.
- R7: Loading an all-zero seed installs the default seed instead, so the register never holds zero.
- R8: `pattern_done` is high for exactly one cycle, in the cycle after every `CHAIN_LEN`-th shift counted from reset or load. The count then starts again from zero.
- R9: Both fan-in 2 and fan-in 3 build and behave as stated in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load `seed_in` and restart the pattern |
| seed_in | input | LFSR_W | Seed value |
| shift_en | input | 1 | Advance one scan shift |
| scan_out | output | 1 | Serial bit toward the scan chain |
| pattern_done | output | 1 | One-cycle pulse after the last bit of a pattern |

## Verification
The bench builds two copies at width 16. One uses fan-in 2 with a chain of 8; the other uses fan-in 3 with a chain of 5. Running both brings the two AND tap sets and two pattern lengths within reach in one run. The short chains let the counter wrap many times, including after a load in mid-pattern. Every cycle the bench compares both copies against its own model of the register, the toggle and the count, over seeds that include the all-zero and all-one values.

// File: rtl/lt_scan_pkg.sv
package lt_scan_pkg;

  // Feedback mask for a left-shifting register of the given width.
  // Widths 8, 16, 24 and 32 are supported; others fall back to width 16.
  function automatic logic [63:0] lfsr_taps(input int width);
    case (width)
      8:       return 64'h0000_0000_0000_00B8;
      16:      return 64'h0000_0000_0000_B400;
      24:      return 64'h0000_0000_00E1_0000;
      32:      return 64'h0000_0000_8020_0003;
      default: return 64'h0000_0000_0000_B400;
    endcase
  endfunction

  localparam logic [63:0] DEFAULT_SEED_WIDE = 64'h96F0_5A3C_ACE1_1D27;

  // Stage feeding input j of the control AND gate.
  function automatic int and_stage(input int j, input int width, input int fan_in);
    return j * (width / fan_in);
  endfunction

endpackage

// File: rtl/lt_lfsr.sv
module lt_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = '0,
  parameter logic [W-1:0] DFLT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst)       state <= DFLT;
    else if (load) state <= (seed == '0) ? DFLT : seed;
    else if (adv)  state <= {state[W-2:0], fb};
  end

  // R7: the register is never zero once out of reset
  p_nonzero_r7: assert property (@(posedge clk) disable iff (rst) state != '0);
  // R5: no advance and no load leaves the register unchanged
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(state));
endmodule

// File: rtl/lt_and_gate.sv
module lt_and_gate #(
  parameter int W = 16,
  parameter int K = 2
) (
  input  logic [W-1:0] state,
  output logic         ctl
);
  logic [K-1:0] picks;
  for (genvar j = 0; j < K; j++) begin : g_pick
    assign picks[j] = state[lt_scan_pkg::and_stage(j, W, K)];
  end
  assign ctl = &picks;
endmodule

// File: rtl/lt_toggle.sv
module lt_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  input  logic t,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clear) q <= 1'b0;
    else if (en && t) q <= ~q;
  end

  // R4: a 1 on the control bit flips the stream
  p_flip_r4: assert property (@(posedge clk) disable iff (rst)
    (!clear && en && t) |=> (q != $past(q)));
  // R4: a 0 on the control bit repeats the last bit
  p_repeat_r4: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(en && t)) |=> $stable(q));
  // R6: a load clears the stream bit
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (q == 1'b0));
endmodule

// File: rtl/lt_pattern_count.sv
module lt_pattern_count #(
  parameter int LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;
  logic          at_last;
  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (adv) begin
      cnt  <= at_last ? '0 : cnt + 1'b1;
      done <= at_last;
    end else begin
      done <= 1'b0;
    end
  end

  // R8: the count stays within the chain length
  p_range_r8: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
  // R8: done needs a shift in the cycle before
  p_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (!adv || clear) |=> !done);
  if (LEN > 1) begin : g_pulse
    // R8: done never lasts two cycles
    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
  end
endmodule

// File: rtl/lt_scan_gen.sv
module lt_scan_gen #(
  parameter int LFSR_W   = 16,
  parameter int AND_K    = 2,
  parameter int CHAIN_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_in,
  input  logic              shift_en,
  output logic              scan_out,
  output logic              pattern_done
);
  localparam logic [63:0]       TAPS_WIDE = lt_scan_pkg::lfsr_taps(LFSR_W);
  localparam logic [LFSR_W-1:0] TAPS      = TAPS_WIDE[LFSR_W-1:0];
  localparam logic [LFSR_W-1:0] DFLT      = lt_scan_pkg::DEFAULT_SEED_WIDE[LFSR_W-1:0];

  logic [LFSR_W-1:0] lfsr_q;
  logic              and_ctl;
  logic              adv;

  assign adv = shift_en && !seed_load;

  lt_lfsr #(.W(LFSR_W), .TAPS(TAPS), .DFLT(DFLT)) u_lfsr (
    .clk(clk), .rst(rst), .load(seed_load), .seed(seed_in),
    .adv(adv), .state(lfsr_q)
  );

  lt_and_gate #(.W(LFSR_W), .K(AND_K)) u_and (
    .state(lfsr_q), .ctl(and_ctl)
  );

  lt_toggle u_tff (
    .clk(clk), .rst(rst), .clear(seed_load), .en(adv),
    .t(and_ctl), .q(scan_out)
  );

  lt_pattern_count #(.LEN(CHAIN_LEN)) u_cnt (
    .clk(clk), .rst(rst), .clear(seed_load), .adv(adv),
    .done(pattern_done)
  );

  // R6: load wins over shift, so stream and pulse are cleared
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (!scan_out && !pattern_done));
  // R5: an idle cycle changes nothing on the stream
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !shift_en) |=> ($stable(scan_out) && !pattern_done));
endmodule

// File: tb/tb_lt_scan_gen.sv
`timescale 1ns/1ps
module tb_lt_scan_gen;
  localparam int LEN2 = 8;
  localparam int LEN3 = 5;
  localparam logic [15:0] DFLT = 16'h1D27;
  localparam logic [15:0] SEEDS [6] = '{16'h0001, 16'hFFFF, 16'h8000,
                                       16'h5555, 16'h0000, 16'hF0F0};
  localparam int RUNS [6] = '{20, 33, 17, 26, 40, 19};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seed_load = 1'b0;
  logic shift_en = 1'b0;
  logic [15:0] seed_in = '0;
  logic so2, pd2, so3, pd3;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lt_scan_gen #(.LFSR_W(16), .AND_K(2), .CHAIN_LEN(LEN2)) dut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_in(seed_in),
    .shift_en(shift_en), .scan_out(so2), .pattern_done(pd2));

  lt_scan_gen #(.LFSR_W(16), .AND_K(3), .CHAIN_LEN(LEN3)) dut_k3 (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_in(seed_in),
    .shift_en(shift_en), .scan_out(so3), .pattern_done(pd3));

  // model state
  logic [15:0] l2, l3;
  logic t2, t3, d2, d3;
  int c2, c3;

  task automatic mstep(input logic ld, input logic sh, input logic [15:0] sd,
                       input int k, input int len,
                       inout logic [15:0] l, inout logic t, inout int c,
                       output logic d);
    logic ctl, fb;
    if (ld) begin
      l = (sd == 16'h0) ? DFLT : sd; t = 1'b0; c = 0; d = 1'b0;
    end else if (sh) begin
      ctl = (k == 2) ? (l[0] & l[8]) : (l[0] & l[5] & l[10]);
      fb  = l[15] ^ l[13] ^ l[12] ^ l[10];
      t   = t ^ ctl;
      l   = {l[14:0], fb};
      d   = (c == len - 1);
      c   = d ? 0 : c + 1;
    end else begin
      d = 1'b0;
    end
  endtask

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "k2 scan_out", so2, t2);
    check(tag, "k2 pattern_done", pd2, d2);
    check(tag, "k3 scan_out", so3, t3);
    check(tag, "k3 pattern_done", pd3, d3);
  endtask

  // drive one cycle after a falling edge, then check at the next falling edge
  task automatic cyc(input logic ld, input logic sh, input logic [15:0] sd,
                     input string tag);
    seed_load = ld; shift_en = sh; seed_in = sd;
    mstep(ld, sh, sd, 2, LEN2, l2, t2, c2, d2);
    mstep(ld, sh, sd, 3, LEN3, l3, t3, c3, d3);
    @(negedge clk);
    compare(tag);
  endtask

  int pd_seen;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    l2 = DFLT; l3 = DFLT; t2 = 0; t3 = 0; c2 = 0; c3 = 0; d2 = 0; d3 = 0;
    compare("R1");
    // R1/R2: default seed drives the stream straight after reset
    for (int i = 0; i < 24; i++) cyc(1'b0, 1'b1, 16'h0, "R1_R2");

    // table walk: load each seed then shift, with an idle cycle every 7th
    for (int s = 0; s < 6; s++) begin
      cyc(1'b1, 1'b0, SEEDS[s], (SEEDS[s] == 0) ? "R7" : "R6");
      for (int i = 0; i < RUNS[s]; i++)
        cyc(1'b0, (i % 7) != 6, 16'h0, (i % 7) != 6 ? "R4_R9" : "R5");
    end

    // R5: a long idle stretch holds everything
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 16'h0, "R5");
    cyc(1'b0, 1'b1, 16'h0, "R5");

    // R6: load and shift together, load wins
    cyc(1'b1, 1'b1, 16'hC3A5, "R6");
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, 16'h0, "R3");

    // R8: reload mid-pattern restarts the count
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 16'h0, "R8");
    cyc(1'b1, 1'b0, 16'h7E11, "R8");
    pd_seen = 0;
    for (int i = 0; i < LEN2; i++) begin
      cyc(1'b0, 1'b1, 16'h0, "R8");
      if (pd2) pd_seen++;
    end
    checks++;
    if (pd_seen != 1 || !pd2) begin
      errors++;
      $display("FAIL R8 pulses after %0d shifts: actual=%0d/%b expected=1/1",
               LEN2, pd_seen, pd2);
    end
    cyc(1'b0, 1'b1, 16'h0, "R8");

    // R7: all-zero seed gives the default stream
    cyc(1'b1, 1'b0, 16'h0000, "R7");
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b1, 16'h0, "R7");

    // R1: reset in mid-run
    rst = 1'b1; shift_en = 1'b1;
    @(negedge clk);
    rst = 1'b0; shift_en = 1'b0;
    l2 = DFLT; l3 = DFLT; t2 = 0; t3 = 0; c2 = 0; c3 = 0; d2 = 0; d3 = 0;
    compare("R1");
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 16'h0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule